// File: doc/BRIEF.md
# Tag-and-Zero Block Store Sequencer

This block carries out a privileged "write allocation tags and clear a block" operation. A single command supplies a base address, a flag that marks the base as the stack pointer, a source word, the current exception level and a block-size exponent. The sequencer first checks privilege and, for a stack-pointer base, alignment. It then rounds the base down to the block boundary and walks the block one 16-byte tag granule at a time. For each granule it issues a 128-bit data write of all zeros and a 4-bit tag write to the same address.

The data channel and the tag channel each have their own valid/ready handshake and may be accepted in any order. The walk moves to the next granule once both beats of the current granule have been taken. The writes are unchecked: no existing tag is read or compared. The result is reported as a one-cycle pulse on exactly one of three outputs: done, undefined, or alignment fault.

Top module: `tagzero_seq`

## Requirements
- R1: The block size is 4·2^bs bytes for the 4-bit field `cmd_bs`. A size below 16 bytes (bs = 0 or 1) is treated as one 16-byte granule.
- R2: The first write address is `cmd_base` rounded down to a multiple of the block size.
- R3: Exactly (block size / 16) data beats and (block size / 16) tag beats are issued, one of each per granule. Addresses run from the aligned base upward in steps of 16, and every write address has bits [3:0] equal to zero.
- R4: Every tag beat carries `cmd_src[3:0]` on `twr_tag`.
- R5: Every data beat carries 128 zero bits on `dwr_data`. A granule's data and tag beats carry the same address.
- R6: A command with `cmd_el` = 0 yields a one-cycle `fault_undef` pulse in the cycle after acceptance, and no write beat is issued. This check takes priority over the alignment check.
- R7: A command with `cmd_use_sp` = 1 and `cmd_base[3:0]` ≠ 0 (at a nonzero level) yields a one-cycle `fault_align` pulse in the cycle after acceptance, and no write beat is issued. A misaligned base with `cmd_use_sp` = 0 is accepted normally.
- R8: Once a write valid is raised, it stays high with stable address and payload until its ready is seen.
- R9: `done` pulses for one cycle, in the cycle after the last granule's data and tag beats have both been accepted. `cmd_ready` is low whenever a write is pending, and at most one of `done`, `fault_undef` and `fault_align` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when idle and able to take a command |
| cmd_base | input | ADDR_W | Base address |
| cmd_use_sp | input | 1 | Base is the stack pointer (enables alignment check) |
| cmd_src | input | SRC_W | Source word; bits [3:0] give the tag |
| cmd_el | input | EL_W | Current exception level |
| cmd_bs | input | BS_W | Block-size exponent |
| dwr_valid | output | 1 | Data write request |
| dwr_ready | input | 1 | Data write accepted |
| dwr_addr | output | ADDR_W | Data write address |
| dwr_data | output | DATA_W | Data write payload (zeros) |
| twr_valid | output | 1 | Tag write request |
| twr_ready | input | 1 | Tag write accepted |
| twr_addr | output | ADDR_W | Tag write address |
| twr_tag | output | TAG_W | Tag value |
| done | output | 1 | Block finished pulse |
| fault_undef | output | 1 | Privilege fault pulse |
| fault_align | output | 1 | Stack-pointer alignment fault pulse |

## Verification
A wrong granule counter or address register shows up immediately at the ports. It appears as a write address that departs from the expected ascending sequence on the very next accepted beat, or as a beat count that differs from the block size by the time `done` pulses. A broken handshake tracker shows up within one stalled cycle: a valid drops or an address changes while ready is low, or `done` arrives before both channels of the last granule have been taken. Faulty privilege or alignment decoding is visible in the cycle after acceptance, as a wrong response pulse or as any write valid at all.

// File: rtl/tzs_pkg.sv
// Shared types for the tag-and-zero sequencer.
// Assumes: only two controller states are needed (idle, walking).
package tzs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tzs_state_e;

    localparam int NUM_CHAN = 2;   // channel 0: data, channel 1: tag
endpackage

// File: rtl/tzs_decode.sv
// Command decode: privilege and stack-pointer alignment checks, block size,
// aligned base address and granule count (minus one).
// Assumes: ADDR_W is wide enough to hold the largest block offset.
module tzs_decode #(
    parameter int ADDR_W    = 64,
    parameter int BS_W      = 4,
    parameter int EL_W      = 2,
    parameter int GRAN_LOG2 = 4,
    localparam int MAX_LOG2 = (1 << BS_W) + 1,
    localparam int LOG_W    = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W    = MAX_LOG2 - GRAN_LOG2 + 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              use_sp,
    input  logic [EL_W-1:0]   el,
    input  logic [BS_W-1:0]   bs,
    output logic              undef,
    output logic              misalign,
    output logic [ADDR_W-1:0] aligned_base,
    output logic [CNT_W-1:0]  count_m1
);
    logic [LOG_W-1:0] raw_log2;
    logic [LOG_W-1:0] blk_log2;

    // Privilege and alignment checks; the caller gives undef priority.
    always_comb begin
        undef    = (el == '0);
        misalign = use_sp && (base[GRAN_LOG2-1:0] != '0);
    end

    // Block size log2 = bs + 2, clamped to at least one granule.
    always_comb begin
        raw_log2 = LOG_W'(bs) + LOG_W'(2);
        blk_log2 = (raw_log2 < LOG_W'(GRAN_LOG2)) ? LOG_W'(GRAN_LOG2) : raw_log2;
    end

    // Round the base down and derive the number of granules.
    always_comb begin
        aligned_base = base & ~((ADDR_W'(1) << blk_log2) - ADDR_W'(1));
        count_m1     = (CNT_W'(1) << (blk_log2 - LOG_W'(GRAN_LOG2))) - CNT_W'(1);
    end
endmodule

// File: rtl/tzs_beat.sv
// One write channel's pending flag: arm raises valid, ready clears it.
// Assumes: arm is never asserted while a beat on this channel is still pending.
module tzs_beat (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ready,
    output logic valid
);
    // Hold valid from arm until the handshake completes.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (arm)   valid <= 1'b1;
        else if (ready) valid <= 1'b0;
    end
endmodule

// File: rtl/tagzero_seq.sv
// Tag-and-zero block store sequencer top level.
// Takes a command, checks it, then writes a zero data beat and a tag beat
// per 16-byte granule of the aligned block, and pulses a single response.
// Assumes: the two write channels are independent; the downstream memory side
// performs no tag comparison.
module tagzero_seq
    import tzs_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int SRC_W     = 64,
    parameter int DATA_W    = 128,
    parameter int TAG_W     = 4,
    parameter int BS_W      = 4,
    parameter int EL_W      = 2,
    parameter int GRAN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic              cmd_use_sp,
    input  logic [SRC_W-1:0]  cmd_src,
    input  logic [EL_W-1:0]   cmd_el,
    input  logic [BS_W-1:0]   cmd_bs,
    output logic              dwr_valid,
    input  logic              dwr_ready,
    output logic [ADDR_W-1:0] dwr_addr,
    output logic [DATA_W-1:0] dwr_data,
    output logic              twr_valid,
    input  logic              twr_ready,
    output logic [ADDR_W-1:0] twr_addr,
    output logic [TAG_W-1:0]  twr_tag,
    output logic              done,
    output logic              fault_undef,
    output logic              fault_align
);
    localparam int MAX_LOG2 = (1 << BS_W) + 1;
    localparam int CNT_W    = MAX_LOG2 - GRAN_LOG2 + 1;
    localparam logic [ADDR_W-1:0] GRAN_BYTES = ADDR_W'(1) << GRAN_LOG2;

    tzs_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [TAG_W-1:0]  tag_q;

    logic              dec_undef, dec_misalign;
    logic [ADDR_W-1:0] dec_base;
    logic [CNT_W-1:0]  dec_cnt_m1;

    logic              accept, gran_end, last_gran, arm;
    logic [NUM_CHAN-1:0] ch_valid, ch_ready, ch_clear;

    tzs_decode #(
        .ADDR_W   (ADDR_W),
        .BS_W     (BS_W),
        .EL_W     (EL_W),
        .GRAN_LOG2(GRAN_LOG2)
    ) u_decode (
        .base        (cmd_base),
        .use_sp      (cmd_use_sp),
        .el          (cmd_el),
        .bs          (cmd_bs),
        .undef       (dec_undef),
        .misalign    (dec_misalign),
        .aligned_base(dec_base),
        .count_m1    (dec_cnt_m1)
    );

    // Both write channels share one arm strobe; each tracks its own handshake.
    generate
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
            tzs_beat u_beat (
                .clk  (clk),
                .rst_n(rst_n),
                .arm  (arm),
                .ready(ch_ready[c]),
                .valid(ch_valid[c])
            );
            assign ch_clear[c] = !ch_valid[c] || ch_ready[c];
        end
    endgenerate

    // Channel mapping and constant / registered payloads.
    always_comb begin
        ch_ready  = {twr_ready, dwr_ready};
        dwr_valid = ch_valid[0];
        twr_valid = ch_valid[1];
        dwr_addr  = addr_q;
        twr_addr  = addr_q;
        dwr_data  = '0;
        twr_tag   = tag_q;
    end

    // Sequencing conditions: command accept, granule end, next-beat arm.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        accept    = cmd_valid && cmd_ready;
        gran_end  = (state == ST_RUN) && (&ch_clear);
        last_gran = (remain_q == '0);
        arm       = (accept && !dec_undef && !dec_misalign) || (gran_end && !last_gran);
    end

    // Controller: latch command, walk granules, pulse the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            addr_q      <= '0;
            remain_q    <= '0;
            tag_q       <= '0;
            done        <= 1'b0;
            fault_undef <= 1'b0;
            fault_align <= 1'b0;
        end else begin
            done        <= 1'b0;
            fault_undef <= 1'b0;
            fault_align <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_undef) begin
                            fault_undef <= 1'b1;
                        end else if (dec_misalign) begin
                            fault_align <= 1'b1;
                        end else begin
                            state    <= ST_RUN;
                            addr_q   <= dec_base;
                            remain_q <= dec_cnt_m1;
                            tag_q    <= cmd_src[TAG_W-1:0];
                        end
                    end
                end
                ST_RUN: begin
                    if (gran_end) begin
                        if (last_gran) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            addr_q   <= addr_q + GRAN_BYTES;
                            remain_q <= remain_q - CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tzs_chk.sv
// Protocol checker for tagzero_seq, attached with bind.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module tzs_chk #(
    parameter int ADDR_W    = 64,
    parameter int TAG_W     = 4,
    parameter int GRAN_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              dwr_valid,
    input logic              dwr_ready,
    input logic [ADDR_W-1:0] dwr_addr,
    input logic              twr_valid,
    input logic              twr_ready,
    input logic [ADDR_W-1:0] twr_addr,
    input logic [TAG_W-1:0]  twr_tag,
    input logic              done,
    input logic              fault_undef,
    input logic              fault_align
);
    p_busy_blocks_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_valid || twr_valid) |-> !cmd_ready);

    p_dhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_valid && !dwr_ready) |=> (dwr_valid && $stable(dwr_addr)));

    p_thold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (twr_valid && !twr_ready) |=> (twr_valid && $stable(twr_addr) && $stable(twr_tag)));

    p_gran_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_valid |-> (dwr_addr[GRAN_LOG2-1:0] == '0));

    p_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_valid && twr_valid) |-> (dwr_addr == twr_addr));

    p_undef_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_undef |-> (!dwr_valid && !twr_valid));

    p_align_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_align |-> (!dwr_valid && !twr_valid));

    p_resp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault_undef, fault_align}));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind tagzero_seq tzs_chk #(
    .ADDR_W   (ADDR_W),
    .TAG_W    (TAG_W),
    .GRAN_LOG2(GRAN_LOG2)
) u_tzs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .dwr_valid  (dwr_valid),
    .dwr_ready  (dwr_ready),
    .dwr_addr   (dwr_addr),
    .twr_valid  (twr_valid),
    .twr_ready  (twr_ready),
    .twr_addr   (twr_addr),
    .twr_tag    (twr_tag),
    .done       (done),
    .fault_undef(fault_undef),
    .fault_align(fault_align)
);

// File: tb/test_tagzero_seq.sv
`timescale 1ns/1ps
module test_tagzero_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [63:0]  cmd_base = '0;
    logic         cmd_use_sp = 1'b0;
    logic [63:0]  cmd_src = '0;
    logic [1:0]   cmd_el = '0;
    logic [3:0]   cmd_bs = '0;
    logic         dwr_valid, twr_valid;
    logic         dwr_ready = 1'b0, twr_ready = 1'b0;
    logic [63:0]  dwr_addr, twr_addr;
    logic [127:0] dwr_data;
    logic [3:0]   twr_tag;
    logic         done, fault_undef, fault_align;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    tagzero_seq i_tagzero_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
        .cmd_use_sp(cmd_use_sp), .cmd_src(cmd_src), .cmd_el(cmd_el), .cmd_bs(cmd_bs),
        .dwr_valid(dwr_valid), .dwr_ready(dwr_ready), .dwr_addr(dwr_addr), .dwr_data(dwr_data),
        .twr_valid(twr_valid), .twr_ready(twr_ready), .twr_addr(twr_addr), .twr_tag(twr_tag),
        .done(done), .fault_undef(fault_undef), .fault_align(fault_align)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reset state: idle, no writes, no response.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R9", "cmd_ready after reset", 64'(cmd_ready), 64'd1);
        chk(!dwr_valid && !twr_valid, "R3", "no write after reset",
            64'({dwr_valid, twr_valid}), 64'd0);
        chk(!done && !fault_undef && !fault_align, "R9", "no response after reset",
            64'({done, fault_undef, fault_align}), 64'd0);
    endtask

    // Issue one command and check every beat and the response.
    // mode: 0 both ready, 1 both stalled in different rhythms, 2 tag stalled.
    // expf: 0 done expected, 1 undef, 2 alignment fault.
    task automatic run_cmd(input logic [63:0] base, input bit use_sp, input logic [63:0] src,
                           input logic [1:0] el, input logic [3:0] bs, input int mode,
                           input int expf);
        int          lg;
        logic [63:0] ebase;
        int          ecnt;
        int          nd = 0, nt = 0;
        int          seen_done = 0, seen_u = 0, seen_a = 0;
        int          done_cyc = -1, u_cyc = -1, a_cyc = -1, last_cyc = -1;
        bit          fin = 0;
        bit          d_stall = 0, t_stall = 0;
        logic [63:0] d_prev = '0, t_prev = '0;
        int          cyc = 0;
        lg    = (int'(bs) + 2 < 4) ? 4 : int'(bs) + 2;
        ebase = base & ~((64'd1 << lg) - 64'd1);
        ecnt  = (expf == 0) ? (1 << (lg - 4)) : 0;

        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_base   = base;
        cmd_use_sp = use_sp;
        cmd_src    = src;
        cmd_el     = el;
        cmd_bs     = bs;
        @(negedge clk);
        cmd_valid  = 1'b0;

        while (!fin && cyc < 20000) begin
            if (done)        begin seen_done++; done_cyc = cyc; fin = 1; end
            if (fault_undef) begin seen_u++;    u_cyc = cyc;    fin = 1; end
            if (fault_align) begin seen_a++;    a_cyc = cyc;    fin = 1; end
            if ((dwr_valid || twr_valid) && cmd_ready)
                chk(0, "R9", "cmd_ready while write pending", 64'(cmd_ready), 64'd0);
            if (d_stall)
                chk(dwr_valid && dwr_addr == d_prev, "R8", "data beat held", dwr_addr, d_prev);
            if (t_stall)
                chk(twr_valid && twr_addr == t_prev, "R8", "tag beat held", twr_addr, t_prev);
            case (mode)
                1:       begin dwr_ready = (cyc % 3 == 2); twr_ready = (cyc % 2 == 0); end
                2:       begin dwr_ready = 1'b1;           twr_ready = (cyc % 5 == 4); end
                default: begin dwr_ready = 1'b1;           twr_ready = 1'b1;           end
            endcase
            #1;
            if (dwr_valid && dwr_ready) begin
                chk(dwr_addr == ebase + 64'(nd) * 64'd16, "R2", "data beat address",
                    dwr_addr, ebase + 64'(nd) * 64'd16);
                chk(dwr_data == '0, "R5", "data beat zero", 64'(|dwr_data), 64'd0);
                nd++;
                if (nd == ecnt && nt >= ecnt) last_cyc = cyc;
            end
            if (twr_valid && twr_ready) begin
                chk(twr_addr == ebase + 64'(nt) * 64'd16, "R3", "tag beat address",
                    twr_addr, ebase + 64'(nt) * 64'd16);
                chk(twr_tag == src[3:0], "R4", "tag value", 64'(twr_tag), 64'(src[3:0]));
                nt++;
                if (nt == ecnt && nd >= ecnt) last_cyc = cyc;
            end
            d_stall = dwr_valid && !dwr_ready;
            t_stall = twr_valid && !twr_ready;
            d_prev  = dwr_addr;
            t_prev  = twr_addr;
            @(negedge clk);
            cyc++;
        end
        dwr_ready = 1'b0;
        twr_ready = 1'b0;
        // One more idle cycle: no stray pulse or write after the response.
        chk(!done && !fault_undef && !fault_align && !dwr_valid && !twr_valid, "R9",
            "quiet after response",
            64'({done, fault_undef, fault_align, dwr_valid, twr_valid}), 64'd0);
        chk(cmd_ready == 1'b1, "R9", "idle after response", 64'(cmd_ready), 64'd1);

        chk(fin, "R9", "response seen before limit", 64'(fin), 64'd1);
        chk(nd == ecnt, (expf == 0) ? "R3" : (expf == 1 ? "R6" : "R7"),
            "data beat count", 64'(nd), 64'(ecnt));
        chk(nt == ecnt, (expf == 0) ? "R1" : (expf == 1 ? "R6" : "R7"),
            "tag beat count", 64'(nt), 64'(ecnt));
        if (expf == 0) begin
            chk(seen_done == 1 && seen_u == 0 && seen_a == 0, "R9", "done only",
                64'({seen_done[3:0], seen_u[3:0], seen_a[3:0]}), 64'h100);
            chk(done_cyc == last_cyc + 1, "R9", "done one cycle after last beat",
                64'(done_cyc), 64'(last_cyc + 1));
        end else if (expf == 1) begin
            chk(seen_u == 1 && seen_done == 0 && seen_a == 0 && u_cyc == 0, "R6",
                "undef pulse after accept",
                64'({seen_done[3:0], seen_u[3:0], seen_a[3:0]}), 64'h010);
        end else begin
            chk(seen_a == 1 && seen_done == 0 && seen_u == 0 && a_cyc == 0, "R7",
                "alignment pulse after accept",
                64'({seen_done[3:0], seen_u[3:0], seen_a[3:0]}), 64'h001);
        end
    endtask

    // R1/R2: 64-byte block from a misaligned non-stack base, full-rate channels.
    task automatic t_basic();
        run_cmd(64'h0000_0000_1234_5678, 1'b0, 64'h0000_0000_000A_BCD7, 2'd1, 4'd4, 0, 0);
    endtask

    // R1: bs = 0 and bs = 1 both clamp to one 16-byte granule.
    task automatic t_min_block();
        run_cmd(64'h0000_0000_0001_003F, 1'b0, 64'h5, 2'd1, 4'd0, 0, 0);
        run_cmd(64'h0000_0000_0000_2008, 1'b0, 64'hFFFF_FFFF_FFFF_FFF2, 2'd2, 4'd1, 0, 0);
    endtask

    // R8: 512-byte block, stack base aligned, both channels stalling.
    task automatic t_stalls();
        run_cmd(64'h0000_0000_8000_0210, 1'b1, 64'h3C, 2'd1, 4'd7, 1, 0);
    endtask

    // R8/R4: tag channel slower than data channel.
    task automatic t_tag_slow();
        run_cmd(64'hFFFF_0000_0000_01F0, 1'b0, 64'h9, 2'd3, 4'd5, 2, 0);
    endtask

    // R6: level 0 rejected, even with a misaligned stack base (priority).
    task automatic t_undef();
        run_cmd(64'h0000_0000_0000_4000, 1'b0, 64'h1, 2'd0, 4'd4, 0, 1);
        run_cmd(64'h0000_0000_0000_4004, 1'b1, 64'h1, 2'd0, 4'd4, 0, 1);
    endtask

    // R7: misaligned stack base faults; same base without stack flag proceeds.
    task automatic t_align();
        run_cmd(64'h0000_0000_0000_7008, 1'b1, 64'hE, 2'd1, 4'd4, 0, 2);
        run_cmd(64'h0000_0000_0000_7008, 1'b0, 64'hE, 2'd1, 4'd4, 0, 0);
    endtask

    // R1/R3: largest block, 8192 granules.
    task automatic t_largest();
        run_cmd(64'h0000_0012_3456_789A, 1'b0, 64'hB, 2'd2, 4'd15, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_min_block();
        t_stalls();
        t_tag_slow();
        t_undef();
        t_align();
        t_largest();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule